// File: doc/BRIEF.md
# Serial Keyboard Protocol Responder

This block stands in for a serial keyboard sitting behind one channel of a serial controller. Key events arrive as a 7-bit key code with a press/release flag. The block turns each event into a one-byte keyboard-to-host code and places it in a byte queue. The host drains the queue one byte at a time. A data-available flag stays high for as long as bytes remain, so every read can raise a fresh receive interrupt.

Host command bytes arrive on a valid/data port. They are acted on only while the channel transmitter is enabled. A reset command and two layout-query commands empty the queue and then load fixed reply sequences. An LED command makes the responder swallow the byte that follows it. All other command bytes are ignored.

The caps-lock and num-lock keys pass through a small filter that removes the extra press and release messages a toggling lock key would otherwise produce. Up to four bytes can enter the queue in one cycle: a reply of up to three bytes plus one key byte. Bytes that find the queue full are dropped.

Top module: `kbd_responder`

## Requirements
- R1: A key press enqueues the byte {0, keyCode}. A key release enqueues {1, keyCode}, so bit 7 carries the release flag and bits 6:0 carry the code.
- R2: The caps-lock code (CAPS_CODE, default 0x77) and the num-lock code (NUM_CODE, default 0x62) each keep a 2-bit state that resets to 0. A press toggles bit 0 and a release toggles bit 1. A press whose new state is 2 enqueues nothing, and a release whose new state is 3 enqueues nothing. Every other key code always enqueues.
- R3: An accepted command 0x01 empties the queue and then enqueues 0xFF, 0x04 and 0x7F, in that order.
- R4: An accepted command 0x0E enqueues nothing, and the next accepted command byte is discarded whatever its value.
- R5: An accepted command 0x07 or 0x0F empties the queue and then enqueues 0xFE and 0x21.
- R6: Any other accepted command byte leaves the queue unchanged.
- R7: A command byte presented while txEnable is low is not accepted. It has no effect on the queue and does not arm the discard of R4.
- R8: The queue holds DEPTH bytes. A byte offered while the queue is full is dropped, and the bytes already queued are kept.
- R9: When the queue is empty, rdData reads 0x00, and a read strobe changes nothing.
- R10: dataAvail is high exactly while the queue holds at least one byte, and bytes leave in the order they entered.
- R11: Within one cycle, events take effect in this order: the read pop, then the empty-and-reply of a command, then the key byte. So a key arriving with a reply command lands after the reply.
- R12: After reset the queue is empty, dataAvail is low and rdData is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyValid | input | 1 | Key event strobe |
| keyCode | input | 7 | Key code of the event |
| keyRelease | input | 1 | 1 = release, 0 = press |
| cmdValid | input | 1 | Host command byte strobe |
| cmdData | input | 8 | Host command byte |
| txEnable | input | 1 | Channel transmitter enable; gates command handling |
| rdStrobe | input | 1 | Host pops the head byte at this clock edge |
| rdData | output | 8 | Head byte of the queue, 0x00 when empty |
| dataAvail | output | 1 | Queue not empty |

## Verification
The bench builds the block with DEPTH set to 8 and the default lock codes. The small depth makes the full-queue drop, the full-queue-then-reply case and pointer wraparound reachable within a few dozen cycles. The default lock codes exercise the whole four-state walk of both filters. The same-cycle orderings of pop, reply and key are driven directly, because a 4-lane enqueue only shows its lane order when those events collide.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  // number of bytes that may enter the queue in one cycle
  localparam int LANES = 4;

  // command bytes understood by the responder
  localparam logic [7:0] CMD_RESET   = 8'h01;
  localparam logic [7:0] CMD_LAYOUT0 = 8'h07;
  localparam logic [7:0] CMD_LEDS    = 8'h0E;
  localparam logic [7:0] CMD_LAYOUT1 = 8'h0F;

  // reply bytes
  localparam logic [7:0] RST_REPLY0 = 8'hFF;
  localparam logic [7:0] RST_REPLY1 = 8'h04;
  localparam logic [7:0] RST_REPLY2 = 8'h7F;
  localparam logic [7:0] LAY_REPLY0 = 8'hFE;
  localparam logic [7:0] LAY_REPLY1 = 8'h21;

  // strobes from control to queue datapath
  typedef struct packed {
    logic                  flush;
    logic [2:0]            cnt;
    logic [LANES-1:0][7:0] bytes;
  } qwr_t;

  typedef enum logic {CMD_IDLE, CMD_SKIP} cmdSt_t;
endpackage

// File: rtl/kbd_ctrl.sv
module kbd_ctrl
  import kbd_pkg::*;
#(
  parameter logic [6:0] CAPS_CODE = 7'h77,
  parameter logic [6:0] NUM_CODE  = 7'h62
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyValid,
  input  logic [6:0] keyCode,
  input  logic       keyRelease,
  input  logic       cmdValid,
  input  logic [7:0] cmdData,
  input  logic       txEnable,
  output qwr_t       qWr
);
  localparam int NLOCK = 2;
  localparam logic [NLOCK-1:0][6:0] LOCK_CODES = {NUM_CODE, CAPS_CODE};

  // ---------------- lock-key filter ----------------
  logic [NLOCK-1:0] lockDrop;

  for (genvar g = 0; g < NLOCK; g++) begin : g_lock
    logic [1:0] lockSt;
    logic [1:0] lockNxt;
    logic       lockHit;

    always_comb begin
      lockHit = keyValid && (keyCode == LOCK_CODES[g]);
      lockNxt = keyRelease ? (lockSt ^ 2'b10) : (lockSt ^ 2'b01);
      lockDrop[g] = lockHit && (keyRelease ? (lockNxt == 2'd3) : (lockNxt == 2'd2));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        lockSt <= 2'd0;
      else if (lockHit) lockSt <= lockNxt;
    end
  end

  logic       keyPass;
  logic [7:0] keyByte;

  always_comb begin
    keyPass = keyValid && !(|lockDrop);
    keyByte = {keyRelease, keyCode};
  end

  // ---------------- host command handling ----------------
  cmdSt_t     cmdSt, cmdStNxt;
  logic       cmdTake;
  logic       rFlush;
  logic [2:0] rCnt;
  logic [2:0][7:0] rBytes;

  always_comb begin
    cmdTake  = cmdValid && txEnable;
    cmdStNxt = cmdSt;
    rFlush   = 1'b0;
    rCnt     = 3'd0;
    rBytes   = '0;
    if (cmdTake) begin
      if (cmdSt == CMD_SKIP) begin
        cmdStNxt = CMD_IDLE;
      end else begin
        unique case (cmdData)
          CMD_RESET: begin
            rFlush = 1'b1;
            rCnt   = 3'd3;
            rBytes = {RST_REPLY2, RST_REPLY1, RST_REPLY0};
          end
          CMD_LAYOUT0, CMD_LAYOUT1: begin
            rFlush = 1'b1;
            rCnt   = 3'd2;
            rBytes = {8'h00, LAY_REPLY1, LAY_REPLY0};
          end
          CMD_LEDS: cmdStNxt = CMD_SKIP;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdSt <= CMD_IDLE;
    else       cmdSt <= cmdStNxt;
  end

  // ---------------- lane assembly: reply first, key after ----------------
  always_comb begin
    qWr.flush = rFlush;
    qWr.bytes = '0;
    for (int i = 0; i < 3; i++) qWr.bytes[i] = rBytes[i];
    if (keyPass) qWr.bytes[rCnt[1:0]] = keyByte;
    qWr.cnt = rCnt + {2'b00, keyPass};
  end
endmodule

// File: rtl/kbd_queue.sv
module kbd_queue
  import kbd_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  qwr_t       qWr,
  input  logic       rdStrobe,
  output logic [7:0] rdData,
  output logic       dataAvail
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] fill;

  logic          popOk;
  logic [CW-1:0] baseFill;
  logic [AW-1:0] wrBase, rdBase;
  int            room, take;

  always_comb begin
    popOk    = rdStrobe && (fill != '0);
    baseFill = qWr.flush ? '0 : (fill - CW'(popOk));
    room     = DEPTH - int'(baseFill);
    take     = (int'(qWr.cnt) > room) ? room : int'(qWr.cnt);
    wrBase   = qWr.flush ? '0 : wrPtr;
    rdBase   = qWr.flush ? '0 : (rdPtr + AW'(popOk));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fill  <= '0;
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      fill  <= baseFill + CW'(take);
      rdPtr <= rdBase;
      wrPtr <= wrBase + AW'(take);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (i < take) mem[wrBase + AW'(i)] <= qWr.bytes[i];
    end
  end

  always_comb begin
    dataAvail = (fill != '0);
    rdData    = dataAvail ? mem[rdPtr] : 8'h00;
  end
endmodule

// File: rtl/kbd_responder.sv
module kbd_responder
  import kbd_pkg::*;
#(
  parameter int         DEPTH     = 256,
  parameter logic [6:0] CAPS_CODE = 7'h77,
  parameter logic [6:0] NUM_CODE  = 7'h62
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyValid,
  input  logic [6:0] keyCode,
  input  logic       keyRelease,
  input  logic       cmdValid,
  input  logic [7:0] cmdData,
  input  logic       txEnable,
  input  logic       rdStrobe,
  output logic [7:0] rdData,
  output logic       dataAvail
);
  qwr_t qWr;

  kbd_ctrl #(.CAPS_CODE(CAPS_CODE), .NUM_CODE(NUM_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .keyValid(keyValid), .keyCode(keyCode), .keyRelease(keyRelease),
    .cmdValid(cmdValid), .cmdData(cmdData), .txEnable(txEnable),
    .qWr(qWr)
  );

  kbd_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rstN(rstN),
    .qWr(qWr), .rdStrobe(rdStrobe),
    .rdData(rdData), .dataAvail(dataAvail)
  );
endmodule

// File: rtl/kbd_responder_chk.sv
module kbd_responder_chk #(
  parameter logic [6:0] CAPS_CODE = 7'h77,
  parameter logic [6:0] NUM_CODE  = 7'h62
) (
  input logic       clk,
  input logic       rstN,
  input logic       keyValid,
  input logic [6:0] keyCode,
  input logic       keyRelease,
  input logic       cmdValid,
  input logic [7:0] cmdData,
  input logic       txEnable,
  input logic       rdStrobe,
  input logic [7:0] rdData,
  input logic       dataAvail
);
  logic cmdTake, lockHit, skipPend;

  assign cmdTake = cmdValid && txEnable;
  assign lockHit = (keyCode == CAPS_CODE) || (keyCode == NUM_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        skipPend <= 1'b0;
    else if (cmdTake) skipPend <= !skipPend && (cmdData == 8'h0E);
  end

  // R9
  empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataAvail |-> rdData == 8'h00);

  // R10
  avail_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataAvail && !rdStrobe && !cmdTake |=> dataAvail);

  // R1
  key_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && !lockHit && !dataAvail && !cmdTake && !rdStrobe
    |=> dataAvail && rdData == {$past(keyRelease), $past(keyCode)});

  // R3
  reset_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdTake && !skipPend && cmdData == 8'h01 |=> dataAvail && rdData == 8'hFF);

  // R5
  layout_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdTake && !skipPend && (cmdData == 8'h07 || cmdData == 8'h0F)
    |=> dataAvail && rdData == 8'hFE);

  // R7
  cmd_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !txEnable && !keyValid && !rdStrobe
    |=> $stable(rdData) && $stable(dataAvail));
endmodule

bind kbd_responder kbd_responder_chk #(.CAPS_CODE(CAPS_CODE), .NUM_CODE(NUM_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .keyValid(keyValid), .keyCode(keyCode),
  .keyRelease(keyRelease), .cmdValid(cmdValid), .cmdData(cmdData),
  .txEnable(txEnable), .rdStrobe(rdStrobe), .rdData(rdData), .dataAvail(dataAvail)
);

// File: tb/kbd_responder_bench.sv
module kbd_responder_bench;
  localparam int DEPTH = 8;
  localparam logic [6:0] CAPS = 7'h77;
  localparam logic [6:0] NUM  = 7'h62;

  logic clk = 1'b0, rstN = 1'b0;
  logic keyValid = 0, keyRelease = 0, cmdValid = 0, txEnable = 1, rdStrobe = 0;
  logic [6:0] keyCode = '0;
  logic [7:0] cmdData = '0;
  logic [7:0] rdData;
  logic dataAvail;

  always #2 clk = ~clk;

  kbd_responder #(.DEPTH(DEPTH), .CAPS_CODE(CAPS), .NUM_CODE(NUM)) u_kbd_responder (
    .clk(clk), .rstN(rstN), .keyValid(keyValid), .keyCode(keyCode),
    .keyRelease(keyRelease), .cmdValid(cmdValid), .cmdData(cmdData),
    .txEnable(txEnable), .rdStrobe(rdStrobe), .rdData(rdData), .dataAvail(dataAvail)
  );

  int tests = 0, fails = 0;
  logic [7:0] got [64];
  int gotN;

  typedef struct packed {
    logic       isCmd;
    logic       rel;
    logic [7:0] val;
    logic [1:0] n;
    logic [7:0] e0, e1, e2;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 8'h10, 2'd1, 8'h10, 8'h00, 8'h00}, // R1 press
    '{1'b0, 1'b1, 8'h10, 2'd1, 8'h90, 8'h00, 8'h00}, // R1 release
    '{1'b0, 1'b0, 8'h77, 2'd1, 8'h77, 8'h00, 8'h00}, // R2 caps 0->1
    '{1'b0, 1'b1, 8'h77, 2'd0, 8'h00, 8'h00, 8'h00}, // R2 caps 1->3 drop
    '{1'b0, 1'b0, 8'h77, 2'd0, 8'h00, 8'h00, 8'h00}, // R2 caps 3->2 drop
    '{1'b0, 1'b1, 8'h77, 2'd1, 8'hF7, 8'h00, 8'h00}, // R2 caps 2->0
    '{1'b0, 1'b0, 8'h62, 2'd1, 8'h62, 8'h00, 8'h00}, // R2 num 0->1
    '{1'b0, 1'b1, 8'h62, 2'd0, 8'h00, 8'h00, 8'h00}, // R2 num 1->3 drop
    '{1'b1, 1'b0, 8'h01, 2'd3, 8'hFF, 8'h04, 8'h7F}, // R3
    '{1'b1, 1'b0, 8'h07, 2'd2, 8'hFE, 8'h21, 8'h00}, // R5
    '{1'b1, 1'b0, 8'h0F, 2'd2, 8'hFE, 8'h21, 8'h00}, // R5
    '{1'b1, 1'b0, 8'h0E, 2'd0, 8'h00, 8'h00, 8'h00}, // R4 enter
    '{1'b1, 1'b0, 8'h01, 2'd0, 8'h00, 8'h00, 8'h00}, // R4 skipped
    '{1'b1, 1'b0, 8'h01, 2'd3, 8'hFF, 8'h04, 8'h7F}, // R4 back to normal
    '{1'b1, 1'b0, 8'h55, 2'd0, 8'h00, 8'h00, 8'h00}, // R6
    '{1'b0, 1'b0, 8'h62, 2'd0, 8'h00, 8'h00, 8'h00}, // R2 num 3->2 drop
    '{1'b0, 1'b1, 8'h62, 2'd1, 8'hE2, 8'h00, 8'h00}, // R2 num 2->0
    '{1'b0, 1'b0, 8'h7F, 2'd1, 8'h7F, 8'h00, 8'h00}  // R1 top code
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic sendKey(input logic [6:0] c, input logic r);
    keyValid = 1; keyCode = c; keyRelease = r;
    @(negedge clk);
    keyValid = 0;
  endtask

  task automatic sendCmd(input logic [7:0] d);
    cmdValid = 1; cmdData = d;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic drain();
    gotN = 0;
    while (dataAvail && gotN < 64) begin
      got[gotN] = rdData;
      gotN++;
      rdStrobe = 1;
      @(negedge clk);
      rdStrobe = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    chk(dataAvail == 0, "R12 dataAvail", dataAvail, 0);
    chk(rdData == 8'h00, "R12 rdData", rdData, 0);

    // R9 read on empty
    rdStrobe = 1; @(negedge clk); rdStrobe = 0;
    chk(dataAvail == 0 && rdData == 8'h00, "R9 empty read", rdData, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].isCmd) sendCmd(VECS[v].val);
      else               sendKey(VECS[v].val[6:0], VECS[v].rel);
      drain();
      chk(gotN == int'(VECS[v].n), $sformatf("R10 vec%0d count", v), gotN, VECS[v].n);
      if (gotN >= 1 && VECS[v].n >= 1) chk(got[0] == VECS[v].e0, $sformatf("R1 vec%0d byte0", v), got[0], VECS[v].e0);
      if (gotN >= 2 && VECS[v].n >= 2) chk(got[1] == VECS[v].e1, $sformatf("R3 vec%0d byte1", v), got[1], VECS[v].e1);
      if (gotN >= 3 && VECS[v].n >= 3) chk(got[2] == VECS[v].e2, $sformatf("R3 vec%0d byte2", v), got[2], VECS[v].e2);
    end

    // R7: commands ignored with transmitter off, no LED arm
    sendKey(7'h11, 0);
    txEnable = 0;
    sendCmd(8'h01);
    chk(dataAvail && rdData == 8'h11, "R7 cmd gated", rdData, 8'h11);
    sendCmd(8'h0E);
    txEnable = 1;
    sendCmd(8'h07);
    drain();
    chk(gotN == 2 && got[0] == 8'hFE, "R7 no led arm", got[0], 8'hFE);

    // R8: fill past capacity
    for (int k = 0; k < DEPTH + 2; k++) sendKey(7'(8'h20 + k), 0);
    drain();
    chk(gotN == DEPTH, "R8 full count", gotN, DEPTH);
    chk(got[0] == 8'h20, "R8 first kept", got[0], 8'h20);
    chk(got[DEPTH-1] == 8'(8'h20 + DEPTH - 1), "R8 last kept", got[DEPTH-1], 8'h20 + DEPTH - 1);

    // R8/R3: full queue then reply
    for (int k = 0; k < DEPTH; k++) sendKey(7'(8'h30 + k), 0);
    sendCmd(8'h01);
    drain();
    chk(gotN == 3 && got[2] == 8'h7F, "R8 reply after full", gotN, 3);

    // R11: key with reply command in same cycle
    sendKey(7'h40, 0);
    keyValid = 1; keyCode = 7'h41; keyRelease = 0; cmdValid = 1; cmdData = 8'h0F;
    @(negedge clk);
    keyValid = 0; cmdValid = 0;
    drain();
    chk(gotN == 3, "R11 same-cycle count", gotN, 3);
    chk(got[2] == 8'h41, "R11 key after reply", got[2], 8'h41);

    // R11/R10: pop and key in same cycle
    sendKey(7'h50, 0);
    chk(rdData == 8'h50, "R10 head", rdData, 8'h50);
    rdStrobe = 1; keyValid = 1; keyCode = 7'h51; keyRelease = 1;
    @(negedge clk);
    rdStrobe = 0; keyValid = 0;
    chk(dataAvail && rdData == 8'hD1, "R11 pop then key", rdData, 8'hD1);
    drain();
    chk(gotN == 1, "R10 single left", gotN, 1);

    // R10 wraparound order
    for (int k = 0; k < 5; k++) sendKey(7'(8'h60 + k), 0);
    drain();
    chk(gotN == 5 && got[4] == 8'h64, "R10 wrap order", got[4], 8'h64);

    finishRun();
  end
endmodule